// File: doc/BRIEF.md
# Raster-to-Block Line Buffer Addresser

This block drives the address and strobes of a single-port, 16-bit working SRAM that sits between a raster pixel source and an 8x8 block transform. Incoming pixels are written line by line into one of two eight-line banks. Once a bank is full, its contents are read back in 8x8 block order while the other bank fills. The SRAM is time-shared: the clock runs at twice the pixel rate, and the cycles alternate between a write slot and a read slot.

In colour mode each SRAM word carries a luma sample in bits 7:0 and a chroma sample in bits 15:8. Chroma alternates U, V along the line, starting with U at even pixel positions. Every 16-column by 8-line region is read back as four blocks: two luma blocks, then one U block, then one V block. In grayscale mode each 8-column region gives one luma block. A lane and kind tag travels with every read, so that downstream logic can pick the byte it needs and route it to the right block.

When the bank the writer needs still holds unread data, the block raises a stall towards the pixel source. It also raises the stall once the frame's lines are all stored. The line length in pixels and the number of lines per frame are inputs held stable during a frame. A frame starts on a start pulse.

Top module: `rblk_addr_gen`

## Requirements
- R1: No read of a bank fill begins until all 8 lines of that fill have been written. The j-th fill of a frame (counting from 0) is read only after (j+1)*8*L writes, where L is the line length.
- R2: The first cycle after reset release is a write slot, and slots then alternate every cycle. `sram_we` is high only in write slots and `sram_re` only in read slots, so the two are never high together.
- R3: The first fill of a frame goes to bank 0 (word base 0000h) and later fills alternate between bank 1 (base 4000h) and bank 0. Address bit 14 is the bank and bit 13 is always 0.
- R4: The n-th write of a frame goes to address bank*4000h + line*400h + pixel, with line = (n/L) mod 8 and pixel = n mod L, for any L up to 1024.
- R5: In colour mode (`cfg_color`=1), each 16-pixel region of a fill is read as four blocks in this order: luma at pixel offsets 0-7, luma at offsets 8-15, U at offsets 0,2,..,14, then V at offsets 1,3,..,15. Each block is read row-major, 8 rows by 8 columns, and regions are taken left to right. The tags are: luma `rd_lane`=0 and `rd_kind`=0; U lane 1 and kind 1; V lane 1 and kind 2.
- R6: In grayscale mode (`cfg_color`=0), each 8-pixel region of a fill is read as a single row-major luma block, with `rd_lane`=0 and `rd_kind`=0.
- R7: `stall` is high while idle, including out of reset. During a frame it is high once all of the frame's lines have been written, and also while the bank the next write targets still holds a fill that has not been completely read. Otherwise it is low. A pixel is consumed exactly when `sram_we` is high, which happens in a write slot with `pix_valid` high and `stall` low.
- R8: `rd_blk_last` is high with the 64th read of every block and low on all other reads.
- R9: A frame consists of `cfg_lines`/8 bank fills. `frame_done` pulses for one cycle in the cycle after the frame's final read. After that the block is idle, with no strobes and with `stall` high. Out of reset, `frame_done`, `sram_we` and `sram_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_color | input | 1 | 1: 4:2:2 colour words, 0: grayscale |
| cfg_line_px | input | 11 | Pixels per line (multiple of 16 colour, 8 gray, at most 1024) |
| cfg_lines | input | 12 | Lines per frame (multiple of 8) |
| start | input | 1 | Begin a frame; taken only while idle |
| pix_valid | input | 1 | Source offers a pixel |
| stall | output | 1 | Source must hold its pixel |
| sram_addr | output | 15 | SRAM word address |
| sram_we | output | 1 | SRAM write strobe; pixel consumed |
| sram_re | output | 1 | SRAM read strobe |
| rd_lane | output | 1 | Byte of the read word to use: 0 low, 1 high |
| rd_kind | output | 2 | Block kind of the read: 0 luma, 1 U, 2 V |
| rd_blk_last | output | 1 | Read is the final sample of its block |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can meet in adjacent slots of the same pixel period. One is the reader releasing a bank with its final read. The other is the writer, held by the stall, needing that same bank. A pixel source that never idles provokes this at every bank swap, because colour reads take twice the slots that writes do. The stall output is compared every cycle against a value computed from the bench's own counts of writes and reads. The first write after each release must land at line 0, pixel 0 of the freed bank, with no pixel dropped or repeated.

// File: rtl/rbuf_pkg.sv
// Shared types for the raster-to-block line buffer addresser.
package rbuf_pkg;
    // Sample class carried with every read issued by the block reader.
    typedef enum logic [1:0] {
        KIND_Y = 2'd0,
        KIND_U = 2'd1,
        KIND_V = 2'd2
    } samp_kind_e;
endpackage

// File: rtl/rbuf_wr_ctr.sv
// Raster write counter. Tracks pixel and line position inside the bank
// being filled. Assumes line_px is nonzero and stable during a frame.
// Pulses bank_done with the write of the last pixel of the last line.
module rbuf_wr_ctr #(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fire,
    input  logic [PIX_W:0]    line_px,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              bank_done
);
    logic last_pix;

    // Detect the final pixel of the programmed line length.
    always_comb last_pix = ({1'b0, pix} == (line_px - 1'b1));

    // Bank is complete on the last pixel of the top line index.
    always_comb bank_done = fire && last_pix && (line == {LINE_W{1'b1}});

    // Advance pixel, wrapping into the next line at end of line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pix  <= '0;
            line <= '0;
        end else if (fire) begin
            if (last_pix) begin
                pix  <= '0;
                line <= line + 1'b1;
            end else begin
                pix <= pix + 1'b1;
            end
        end
    end

    // A write never lands beyond the programmed line length.
    p_pix_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ({1'b0, pix} < line_px));
endmodule

// File: rtl/rbuf_rd_ctr.sv
// Block read counter. Walks a full bank in 8x8 block order: column, row,
// block within region, region. Colour regions are 16 pixels wide and give
// two luma blocks then U then V; gray regions are 8 wide with one block.
// Assumes line_px is a multiple of the region width and stable per frame.
module rbuf_rd_ctr
    import rbuf_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fire,
    input  logic              color,
    input  logic [PIX_W:0]    line_px,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] row,
    output samp_kind_e        kind,
    output logic              blk_last,
    output logic              bank_done
);
    localparam int COL_W = 3;
    localparam int REG_W = PIX_W - COL_W;
    localparam int BLK_W = 2;

    logic [COL_W-1:0] col;
    logic [BLK_W-1:0] blk;
    logic [REG_W-1:0] rgn;
    logic [PIX_W:0]   n_rgn;
    logic             last_col, last_row, last_blk, last_rgn;
    logic [PIX_W-1:0] base, off;

    // Region count and position flags for the current sample.
    always_comb begin
        n_rgn    = color ? (line_px >> 4) : (line_px >> 3);
        last_col = (col == {COL_W{1'b1}});
        last_row = (row == {LINE_W{1'b1}});
        last_blk = color ? (blk == {BLK_W{1'b1}}) : 1'b1;
        last_rgn = ({{(PIX_W+1-REG_W){1'b0}}, rgn} == (n_rgn - 1'b1));
    end

    // Map block and column to a pixel offset inside the region.
    always_comb begin
        base = color ? (PIX_W'(rgn) << 4) : (PIX_W'(rgn) << 3);
        off  = PIX_W'(col);
        kind = KIND_Y;
        if (color) begin
            case (blk)
                2'd0: off = PIX_W'(col);
                2'd1: off = PIX_W'(col) + PIX_W'(8);
                2'd2: begin off = PIX_W'(col) << 1;             kind = KIND_U; end
                default: begin off = (PIX_W'(col) << 1) + 1'b1; kind = KIND_V; end
            endcase
        end
        pix = base + off;
    end

    // End-of-block and end-of-bank markers.
    always_comb begin
        blk_last  = last_col && last_row;
        bank_done = fire && blk_last && last_blk && last_rgn;
    end

    // Step column, then row, then block, then region.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col <= '0;
            row <= '0;
            blk <= '0;
            rgn <= '0;
        end else if (fire) begin
            col <= col + 1'b1;
            if (last_col) begin
                row <= row + 1'b1;
                if (last_row) begin
                    if (last_blk) begin
                        blk <= '0;
                        rgn <= last_rgn ? '0 : rgn + 1'b1;
                    end else begin
                        blk <= blk + 1'b1;
                    end
                end
            end
        end
    end

    // After a block ends mid-bank, the next read starts at its top-left.
    p_blk_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && blk_last && !bank_done && !clr) |=> (col == '0 && row == '0));
endmodule

// File: rtl/rbuf_bank_ctl.sv
// Bank controller. Holds per-bank full flags, writer and reader bank
// pointers and the remaining fill counts of a frame. Assumes writer and
// reader completion pulses come from distinct slots.
module rbuf_bank_ctl #(
    parameter int FL_W   = 12,
    parameter int LINE_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FL_W-1:0] cfg_lines,
    input  logic            wr_done,
    input  logic            rd_done,
    output logic            clr,
    output logic            wbank,
    output logic            rbank,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic            frame_done
);
    localparam int CNT_W = FL_W - LINE_W;

    logic             busy;
    logic [1:0]       full;
    logic [CNT_W-1:0] wr_left, rd_left;
    logic [CNT_W-1:0] n_fills;

    // Frame length in bank fills; a new frame is taken only when idle.
    always_comb begin
        n_fills = cfg_lines[FL_W-1:LINE_W];
        clr     = start && !busy;
    end

    // Permission to write the current write bank or read the read bank.
    always_comb begin
        wr_ok = busy && (wr_left != '0) && !full[wbank];
        rd_ok = busy && full[rbank];
    end

    // Bank flags, pointers and frame progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            full       <= 2'b00;
            wbank      <= 1'b0;
            rbank      <= 1'b0;
            wr_left    <= '0;
            rd_left    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (clr) begin
                busy    <= (n_fills != '0);
                full    <= 2'b00;
                wbank   <= 1'b0;
                rbank   <= 1'b0;
                wr_left <= n_fills;
                rd_left <= n_fills;
            end else begin
                if (wr_done) begin
                    full[wbank] <= 1'b1;
                    wbank       <= ~wbank;
                    wr_left     <= wr_left - 1'b1;
                end
                if (rd_done) begin
                    full[rbank] <= 1'b0;
                    rbank       <= ~rbank;
                    rd_left     <= rd_left - 1'b1;
                    if (rd_left == 1) begin
                        busy       <= 1'b0;
                        frame_done <= 1'b1;
                    end
                end
            end
        end
    end

    // A fill that completes never lands on a bank still awaiting reads.
    p_fill_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !full[wbank]);
    // End of frame is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // Reading a bank empties it for the writer.
    p_read_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !clr) |=> !full[$past(rbank)]);
endmodule

// File: rtl/rblk_addr_gen.sv
// Top of the raster-to-block line buffer addresser. Alternates write and
// read slots each cycle, muxes the SRAM address and derives the stall.
// Address layout: bit 14 bank, bit 13 zero, bits 12:10 line, 9:0 pixel.
// Assumes configuration inputs stay stable while a frame is running.
module rblk_addr_gen
    import rbuf_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 3,
    parameter int FL_W   = 12,
    localparam int ADDR_W = PIX_W + LINE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_color,
    input  logic [PIX_W:0]    cfg_line_px,
    input  logic [FL_W-1:0]   cfg_lines,
    input  logic              start,
    input  logic              pix_valid,
    output logic              stall,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_we,
    output logic              sram_re,
    output logic              rd_lane,
    output logic [1:0]        rd_kind,
    output logic              rd_blk_last,
    output logic              frame_done
);
    logic              slot;
    logic              clr, wbank, rbank, wr_ok, rd_ok;
    logic              wr_fire, rd_fire, wr_done, rd_done;
    logic [PIX_W-1:0]  wpix, rpix;
    logic [LINE_W-1:0] wline, rrow;
    samp_kind_e        rkind;
    logic              rblk_last;

    // Slot phase: 0 write, 1 read; first cycle after reset is a write.
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= 1'b0;
        else        slot <= ~slot;
    end

    // Transfers fire only in their own slot when permitted.
    always_comb begin
        wr_fire = !slot && wr_ok && pix_valid;
        rd_fire = slot && rd_ok;
        stall   = !wr_ok;
        sram_we = wr_fire;
        sram_re = rd_fire;
    end

    // Address and read tags for the active slot.
    always_comb begin
        if (slot) sram_addr = {rbank, 1'b0, rrow, rpix};
        else      sram_addr = {wbank, 1'b0, wline, wpix};
        rd_kind     = rkind;
        rd_lane     = (rkind != KIND_Y);
        rd_blk_last = rd_fire && rblk_last;
    end

    rbuf_bank_ctl #(.FL_W(FL_W), .LINE_W(LINE_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_lines(cfg_lines),
        .wr_done(wr_done), .rd_done(rd_done), .clr(clr),
        .wbank(wbank), .rbank(rbank), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .frame_done(frame_done)
    );

    rbuf_wr_ctr #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(wr_fire),
        .line_px(cfg_line_px), .pix(wpix), .line(wline), .bank_done(wr_done)
    );

    rbuf_rd_ctr #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(rd_fire),
        .color(cfg_color), .line_px(cfg_line_px), .pix(rpix), .row(rrow),
        .kind(rkind), .blk_last(rblk_last), .bank_done(rd_done)
    );

    // Read and write strobes never share a cycle.
    p_no_dual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_we && sram_re));
    // Writes can only occur in every other cycle.
    p_we_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> !sram_we);
    // Bit between bank select and line field is never set on a strobe.
    p_gap_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we || sram_re) |-> !sram_addr[ADDR_W-2]);
endmodule

// File: tb/rblk_addr_gen_test.sv
module rblk_addr_gen_test;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_color = 1'b0;
    logic [10:0] cfg_line_px = 11'd16;
    logic [11:0] cfg_lines = 12'd8;
    logic        start = 1'b0;
    logic        pix_valid = 1'b0;
    logic        stall;
    logic [14:0] sram_addr;
    logic        sram_we, sram_re, rd_lane, rd_blk_last, frame_done;
    logic [1:0]  rd_kind;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int gcyc = 0;
    int vmode = 0;
    int gc = 0;
    bit active = 0;
    int nw = 0, nr = 0, dones = 0;
    int L = 16, F = 1, RPB = 128;
    bit col_mode = 0;

    rblk_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_color(cfg_color),
        .cfg_line_px(cfg_line_px), .cfg_lines(cfg_lines), .start(start),
        .pix_valid(pix_valid), .stall(stall), .sram_addr(sram_addr),
        .sram_we(sram_we), .sram_re(sram_re), .rd_lane(rd_lane),
        .rd_kind(rd_kind), .rd_blk_last(rd_blk_last), .frame_done(frame_done)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pixel source: continuous or gappy offer pattern.
    always @(posedge clk) begin
        #1;
        if (vmode == 0) pix_valid = 1'b1;
        else            pix_valid = ((gc % 7) < 4);
        gc++;
    end

    // Monitor: every write, read, stall and end-of-frame event.
    always @(negedge clk) begin
        gcyc++;
        if (!rst_n) cyc = 0;
        else begin
            chk(!(sram_we && sram_re), "R2 dual strobe", 1, 0);
            if (active) begin
                int k;
                bit allowed;
                k = nw / (8 * L);
                allowed = (k < F) && ((k < 2) || (nr >= (k - 1) * RPB));
                chk(stall == !allowed, "R7 stall", stall, !allowed);
            end
            if (sram_we) begin
                int k, ea;
                chk((cyc % 2) == 0, "R2 write slot parity", cyc % 2, 0);
                k  = nw / (8 * L);
                ea = (k % 2) * 16384 + ((nw / L) % 8) * 1024 + (nw % L);
                chk(sram_addr == ea, "R4/R3 write address", sram_addr, ea);
                nw++;
            end
            if (sram_re) begin
                int j, q, rg, s, b, e, r, c, p, ea, ek;
                chk((cyc % 2) == 1, "R2 read slot parity", cyc % 2, 1);
                j = nr / RPB;
                q = nr % RPB;
                chk(nw >= (j + 1) * 8 * L, "R1 read before fill", nw, (j + 1) * 8 * L);
                if (col_mode) begin
                    rg = q / 256; s = q % 256; b = s / 64; e = s % 64;
                    r = e / 8; c = e % 8;
                    case (b)
                        0: p = c;
                        1: p = 8 + c;
                        2: p = 2 * c;
                        default: p = 2 * c + 1;
                    endcase
                    p  = rg * 16 + p;
                    ek = (b < 2) ? 0 : b - 1;
                    ea = (j % 2) * 16384 + r * 1024 + p;
                    chk(sram_addr == ea, "R5 colour read address", sram_addr, ea);
                    chk(rd_kind == ek, "R5 read kind", rd_kind, ek);
                    chk(rd_lane == (ek != 0), "R5 read lane", rd_lane, ek != 0);
                end else begin
                    rg = q / 64; e = q % 64; r = e / 8; c = e % 8;
                    ea = (j % 2) * 16384 + r * 1024 + rg * 8 + c;
                    chk(sram_addr == ea, "R6 gray read address", sram_addr, ea);
                    chk(rd_kind == 0 && rd_lane == 0, "R6 gray tags", {rd_kind, rd_lane}, 0);
                end
                chk(rd_blk_last == ((nr % 64) == 63), "R8 block last", rd_blk_last, (nr % 64) == 63);
                nr++;
            end
            if (frame_done) begin
                chk(nr == F * RPB, "R9 reads at frame end", nr, F * RPB);
                chk(nw == F * 8 * L, "R9 writes at frame end", nw, F * 8 * L);
                chk(stall == 1'b1, "R9 idle stall", stall, 1);
                dones++;
                active = 0;
            end
            cyc++;
        end
        if (gcyc > WDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_frame(input bit color, input int lpx, input int lines, input int vm);
        int d0;
        int t;
        @(posedge clk); #2;
        cfg_color = color; cfg_line_px = lpx[10:0]; cfg_lines = lines[11:0];
        vmode = vm; col_mode = color; L = lpx; F = lines / 8;
        RPB = color ? 16 * lpx : 8 * lpx;
        nw = 0; nr = 0;
        d0 = dones;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        active = 1;
        t = 0;
        while (dones == d0 && t < 60000) begin
            @(posedge clk);
            t++;
        end
        chk(dones == d0 + 1, "R9 frame completes", dones - d0, 1);
        // Idle afterwards: no strobes, stall held (R9).
        repeat (4) begin
            @(negedge clk);
            chk(!sram_we && !sram_re && stall && !frame_done, "R9 idle after frame",
                {sram_we, sram_re, stall, frame_done}, 2);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(stall == 1'b1, "R7 reset stall", stall, 1);
        chk(!sram_we && !sram_re && !frame_done, "R9 reset strobes",
            {sram_we, sram_re, frame_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(stall == 1'b1 && !sram_we, "R7 idle before start", stall, 1);
        run_frame(1'b1, 32, 24, 0);    // R5 colour, three fills, source never idles
        run_frame(1'b0, 16, 16, 1);    // R6 gray, gappy source
        run_frame(1'b1, 16, 8, 1);     // R3 single fill
        run_frame(1'b0, 1024, 16, 0);  // R4 widest line
        run_frame(1'b1, 1024, 8, 0);   // R5 widest colour line
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule